// File: doc/BRIEF.md
# Dual-Bank Programmable Clock Divider

This block turns one fast source clock into two independent divided clocks, bank A and bank B. Each bank has its own 6-bit ratio code, and each bank drives four identical output copies that switch together. A bypass input moves both dividers onto a slower reference clock, which allows static testing and bring-up without the fast source.

The divide ratio is twice the code. One code is reserved and gives an odd ratio of 15. That ratio still has a near-even duty cycle, because a register on the falling edge stretches the high phase by half a source cycle. Codes below the legal range are raised to the smallest legal ratio. A new code takes effect only at the end of the current output period, so the output never shows a short pulse.

After the active-low reset is released, a ready flag rises after a fixed number of divider-clock edges. Until the flag rises, every output stays low. The first output period starts on the edge after the flag rises.

Top module: `clkdiv_dual_bank`

## Requirements
- R1: For a code value c in 4..63 other than 7, a bank divides by N = 2*c: it is high for N/2 divider-clock cycles, then low for N/2 cycles.
- R2: Code value 7 selects N = 15. The output is high for 7.5 cycles (seven rising-edge cycles plus half a cycle) and low for 7.5 cycles.
- R3: Code values 0, 1, 2 and 3 are treated as code 4 (N = 8).
- R4: On both code buses, bit index 0 is the most significant bit and bit index 5 is the least significant bit. For example, the pattern with index 3 and index 5 set means code 5.
- R5: Bank A and bank B take their ratios only from their own code bus, and they may run at different ratios at the same time.
- R6: The four copies of a bank are equal at all times.
- R7: When bypass is high, both dividers and the ready counter count the reference clock instead of the source clock. Bypass is changed only while reset is asserted.
- R8: While rst_ni is low, all bank outputs and ready_o are low, and this does not wait for a clock edge.
- R9: ready_o rises on the 16th divider-clock rising edge after reset release (READY_CYCLES = 16) and then stays high until the next reset.
- R10: While ready_o is low, all bank outputs are low. Each bank starts a period, going high, on the first rising edge at which ready_o is already high.
- R11: A code change takes effect at the next period boundary of that bank. No high phase is shorter than 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Fast source clock |
| ref_clk_i | input | 1 | Reference clock, used when bypass is high |
| bypass_i | input | 1 | Selects the reference clock as the divider clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_a_i | input | 6 | Bank A ratio code, index 0 is the MSB |
| cfg_b_i | input | 6 | Bank B ratio code, index 0 is the MSB |
| ready_o | output | 1 | High once the start-up count has completed |
| bank_a_o | output | 4 | Bank A clock copies |
| bank_b_o | output | 4 | Bank B clock copies |

## Verification
Two events can fall on the same edge: a code change and the end of a bank's period. Another case is a code change while the odd divide is in its extra falling-edge half cycle. The bench changes codes on arbitrary cycles across hundreds of periods, including switches between the odd ratio and even ratios. The same cycles also include the moment that ready rises. A behavioural model tracks the expected level on every half cycle and judges each one. Every rising and falling edge is compared, so a runt pulse, a ratio loaded too early or a wrong extra half cycle all show up as mismatches.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int unsigned CFG_W    = 6;
  localparam int unsigned N_W      = CFG_W + 1;
  localparam int unsigned MIN_CODE = 4;
  localparam int unsigned ODD_CODE = 7;
  localparam int unsigned ODD_N    = 15;

  typedef logic [CFG_W-1:0] code_t;
  typedef logic [N_W-1:0]   ratio_t;

  function automatic ratio_t code_to_ratio(code_t code, bit odd_en);
    if (code < code_t'(MIN_CODE)) return ratio_t'(2 * MIN_CODE);
    if (odd_en && code == code_t'(ODD_CODE)) return ratio_t'(ODD_N);
    return {code, 1'b0};
  endfunction
endpackage

// File: rtl/clkdiv_clk_sel.sv
`timescale 1ns/1ps
module clkdiv_clk_sel (
  input  logic src_clk_i,
  input  logic ref_clk_i,
  input  logic bypass_i,
  output logic clk_o
);
  // bypass is static outside reset, so a plain mux is sufficient
  assign clk_o = bypass_i ? ref_clk_i : src_clk_i;
endmodule

// File: rtl/clkdiv_ready.sv
`timescale 1ns/1ps
module clkdiv_ready #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (cnt_q == CNT_W'(CYCLES - 1)) ready_q <= 1'b1;
      else                             cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int unsigned COPIES = 4,
  parameter bit          ODD_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  code_t             cfg_i,
  output logic [COPIES-1:0] clk_o
);
  ratio_t n_cfg, n_q, cnt_q, cnt_inc;
  logic   r_q, f_q, odd, last, out;

  assign n_cfg   = code_to_ratio(cfg_i, ODD_EN);
  assign cnt_inc = cnt_q + ratio_t'(1);
  assign last    = (cnt_inc == n_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= ratio_t'(2 * MIN_CODE);
      cnt_q <= '0;
      r_q   <= 1'b0;
    end else if (!run_i) begin
      // park at end of period so the first run edge opens a full period
      n_q   <= n_cfg;
      cnt_q <= n_cfg - ratio_t'(1);
      r_q   <= 1'b0;
    end else if (last) begin
      n_q   <= n_cfg;
      cnt_q <= '0;
      r_q   <= 1'b1;
    end else begin
      cnt_q <= cnt_inc;
      r_q   <= (cnt_inc < (n_q >> 1));
    end
  end

  generate
    if (ODD_EN) begin : g_odd
      // half-cycle stretch of the high phase for odd ratios
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= 1'b0;
        else         f_q <= r_q;
      end
      assign odd = n_q[0];
    end else begin : g_even
      assign f_q = 1'b0;
      assign odd = 1'b0;
    end
  endgenerate

  assign out = r_q | (odd & f_q);

  generate
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
      assign clk_o[c] = out;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_dual_bank.sv
`timescale 1ns/1ps
module clkdiv_dual_bank
  import clkdiv_pkg::*;
#(
  parameter int unsigned COPIES       = 4,
  parameter int unsigned READY_CYCLES = 16,
  parameter bit          ODD_EN       = 1'b1
) (
  input  logic              src_clk_i,
  input  logic              ref_clk_i,
  input  logic              bypass_i,
  input  logic              rst_ni,
  input  logic [0:CFG_W-1]  cfg_a_i,
  input  logic [0:CFG_W-1]  cfg_b_i,
  output logic              ready_o,
  output logic [COPIES-1:0] bank_a_o,
  output logic [COPIES-1:0] bank_b_o
);
  localparam int unsigned BANKS = 2;

  logic              div_clk;
  code_t             cfg_nat [BANKS];
  logic [COPIES-1:0] bank_out [BANKS];

  // index 0 is the MSB: positional assignment maps it to bit CFG_W-1
  assign cfg_nat[0] = cfg_a_i;
  assign cfg_nat[1] = cfg_b_i;

  clkdiv_clk_sel u_clk_sel (
    .src_clk_i (src_clk_i),
    .ref_clk_i (ref_clk_i),
    .bypass_i  (bypass_i),
    .clk_o     (div_clk)
  );

  clkdiv_ready #(.CYCLES(READY_CYCLES)) u_ready (
    .clk_i   (div_clk),
    .rst_ni  (rst_ni),
    .ready_o (ready_o)
  );

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      clkdiv_bank #(.COPIES(COPIES), .ODD_EN(ODD_EN)) u_bank (
        .clk_i  (div_clk),
        .rst_ni (rst_ni),
        .run_i  (ready_o),
        .cfg_i  (cfg_nat[b]),
        .clk_o  (bank_out[b])
      );
    end
  endgenerate

  assign bank_a_o = bank_out[0];
  assign bank_b_o = bank_out[1];
endmodule

// File: rtl/clkdiv_dual_bank_chk.sv
`timescale 1ns/1ps
module clkdiv_dual_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int unsigned COPIES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_i,
  input logic [COPIES-1:0] bank_a_i,
  input logic [COPIES-1:0] bank_b_i
);
  localparam int unsigned RUN_W = CFG_W + 1;

  logic [RUN_W-1:0] hi_a_q, hi_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_a_q <= '0;
      hi_b_q <= '0;
    end else begin
      hi_a_q <= !bank_a_i[0] ? '0 : (&hi_a_q ? hi_a_q : hi_a_q + RUN_W'(1));
      hi_b_q <= !bank_b_i[0] ? '0 : (&hi_b_q ? hi_b_q : hi_b_q + RUN_W'(1));
    end
  end

  p_ready_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> ready_i);

  p_quiet_before_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> (bank_a_i == '0 && bank_b_i == '0));

  p_copies_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_a_i == '0 || bank_a_i == '1));

  p_copies_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_b_i == '0 || bank_b_i == '1));

  p_no_runt_a_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bank_a_i[0]) |-> hi_a_q >= RUN_W'(MIN_CODE));

  p_no_runt_b_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bank_b_i[0]) |-> hi_b_q >= RUN_W'(MIN_CODE));
endmodule

bind clkdiv_dual_bank clkdiv_dual_bank_chk #(.COPIES(COPIES)) u_chk (
  .clk_i    (div_clk),
  .rst_ni   (rst_ni),
  .ready_i  (ready_o),
  .bank_a_i (bank_a_o),
  .bank_b_i (bank_b_o)
);

// File: tb/clkdiv_dual_bank_bench.sv
`timescale 1ns/1ps
module clkdiv_dual_bank_bench;
  localparam int COPIES = 4;
  localparam int READY  = 16;

  logic src_clk = 1'b0, ref_clk = 1'b0, bypass = 1'b0, rst_n = 1'b0;
  logic [0:5] cfg_a = 6'd4, cfg_b = 6'd10;
  logic ready;
  logic [COPIES-1:0] bank_a, bank_b;
  logic mclk;

  int checks = 0, failures = 0;
  string cur_req = "R8";
  bit done = 1'b0;

  always #2.5 src_clk = ~src_clk;
  always #10  ref_clk = ~ref_clk;
  assign mclk = bypass ? ref_clk : src_clk;

  clkdiv_dual_bank u_clkdiv_dual_bank (
    .src_clk_i (src_clk),
    .ref_clk_i (ref_clk),
    .bypass_i  (bypass),
    .rst_ni    (rst_n),
    .cfg_a_i   (cfg_a),
    .cfg_b_i   (cfg_b),
    .ready_o   (ready),
    .bank_a_o  (bank_a),
    .bank_b_o  (bank_b)
  );

  // ---------------- reference model ----------------
  function automatic int code_val(logic [0:5] c);
    int v = 0;
    for (int i = 0; i < 6; i++) v = v * 2 + int'(c[i]);  // index 0 weighs most (R4)
    return v;
  endfunction

  function automatic int ratio(int code);
    if (code < 4) return 8;        // R3
    if (code == 7) return 15;      // R2
    return 2 * code;               // R1
  endfunction

  int m_edges;
  bit m_rdy;
  int m_ph [2];
  int m_n [2];
  bit m_rise [2];
  bit m_fall [2];

  always @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges = 0;
      m_rdy   = 1'b0;
      for (int b = 0; b < 2; b++) begin
        m_ph[b] = 0; m_n[b] = 8; m_rise[b] = 1'b0;
      end
    end else begin
      for (int b = 0; b < 2; b++) begin
        int want;
        want = ratio(code_val(b == 0 ? cfg_a : cfg_b));
        if (!m_rdy) begin
          m_n[b] = want; m_ph[b] = want - 1; m_rise[b] = 1'b0;
        end else begin
          m_ph[b]++;
          if (m_ph[b] >= m_n[b]) begin
            m_ph[b] = 0; m_n[b] = want;
          end
          m_rise[b] = (m_ph[b] < m_n[b] / 2);
        end
      end
      m_edges++;
      if (m_edges >= READY) m_rdy = 1'b1;
    end
  end

  always @(negedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      m_fall[0] = 1'b0; m_fall[1] = 1'b0;
    end else begin
      m_fall[0] = m_rise[0]; m_fall[1] = m_rise[1];
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ea, eb;
    if (!rst_n) begin
      check(ready == 1'b0, "R8", "ready in reset", int'(ready), 0);
      check(bank_a == '0 && bank_b == '0, "R8", "banks in reset",
            int'({bank_a, bank_b}), 0);
      return;
    end
    ea = m_rise[0] | ((m_n[0] % 2 == 1) & m_fall[0]);
    eb = m_rise[1] | ((m_n[1] % 2 == 1) & m_fall[1]);
    check(ready == m_rdy, "R9", "ready", int'(ready), int'(m_rdy));
    check(bank_a == '0 || bank_a == '1, "R6", "bank_a copies", int'(bank_a), 0);
    check(bank_b == '0 || bank_b == '1, "R6", "bank_b copies", int'(bank_b), 0);
    check(bank_a == {COPIES{ea}}, m_rdy ? cur_req : "R10", "bank_a",
          int'(bank_a), int'({COPIES{ea}}));
    check(bank_b == {COPIES{eb}}, m_rdy ? cur_req : "R10", "bank_b",
          int'(bank_b), int'({COPIES{eb}}));
  endtask

  always @(posedge mclk or negedge mclk) begin
    #1;
    if (!done) compare();
  end

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    cur_req = "R8";
    repeat (4) @(negedge src_clk);
    #1 check(ready == 1'b0 && bank_a == '0, "R8", "reset state", int'(ready), 0);
    @(negedge src_clk); rst_n = 1'b1;

    cur_req = "R1 R5";            // A: N=8, B: N=20
    repeat (200) @(negedge mclk);

    cur_req = "R2 R11";           // mid-period change to odd and to N=126
    cfg_a = 6'd7; cfg_b = 6'd63;
    repeat (400) @(negedge mclk);
    cfg_a = 6'd12; cfg_b = 6'd7;
    repeat (3) @(negedge mclk);
    cfg_a = 6'd7;
    repeat (200) @(negedge mclk);

    cur_req = "R3";
    cfg_a = 6'd2; cfg_b = 6'd0;
    repeat (150) @(negedge mclk);
    cfg_a = 6'd3; cfg_b = 6'd1;
    repeat (150) @(negedge mclk);

    cur_req = "R4";               // 5 and 48; the reversed reading would give 40 and 3
    cfg_a = 6'b000101; cfg_b = 6'b110000;
    repeat (300) @(negedge mclk);

    cur_req = "R7";
    @(negedge mclk); rst_n = 1'b0;
    #2 bypass = 1'b1; cfg_a = 6'd4; cfg_b = 6'd7;
    #40;
    @(negedge ref_clk); rst_n = 1'b1;
    repeat (250) @(negedge mclk);

    finish_run();
  end
endmodule